// File: doc/BRIEF.md
# Anticollision Bit Collision Position Capture

This block sits behind the receive decoder of a contactless card reader and watches the decoded bit stream during anticollision frames. It numbers every received bit. The count starts at zero on the first bit after the start bit. When the decoder flags a bit as a collision, the block raises a status flag and an interrupt request. Under the proximity Type A protocol it also records the number of the colliding bit. The command byte and the valid-bits count byte come before the UID and are counted, so a collision on the first UID bit reads back as 16.

The 10-bit position is split across two host-visible fields. The low eight bits form a dedicated position byte. The top two bits occupy bits 7:6 of a shared byte whose low six bits are interrupt-mask storage written by the host. The host clears the flag by reading the status register. The captured position stays valid until the next start bit.

The decoded bits arrive as a valid-only stream (`rx_bit_vld`, with `rx_bit_coll` qualifying each bit). There is no ready signal. The block accepts a bit on every cycle that `rx_bit_vld` is high and never applies back-pressure, so the decoder must not hold a bit waiting for acceptance.

Top module: `acoll_pos_capture`

## Requirements
- R1: After reset, `pos_lo`, `pos_mask_reg`, `coll_flag` and `coll_irq` are all zero.
- R2: `rx_start` clears the bit count to zero, so the next accepted bit is position 0. When `rx_start` and `rx_bit_vld` are high in the same cycle, `rx_start` wins: that bit is neither counted nor checked for collision.
- R3: A bit is accepted when `rx_bit_vld` and `frame_on` are both high, and each accepted bit advances the count by one. Bits presented while `frame_on` is low are ignored: they change neither the count nor the flag.
- R4: Under Type A (`proto_type_a` = 1), an accepted bit with `rx_bit_coll` = 1 records its own sequence number. The first bit after 16 preceding bits records 16.
- R5: The recorded 10-bit position appears with bits 7:0 on `pos_lo` and bits 9:8 on `pos_mask_reg[7:6]`, one cycle after the colliding bit.
- R6: Only the first collision after a start bit is recorded. Later collisions in the same frame leave the position unchanged.
- R7: The bit count saturates at 1023 and does not wrap. A collision after more than 1023 bits records 1023.
- R8: Any accepted colliding bit, under either protocol, sets `coll_flag` and `coll_irq` one cycle later. `coll_irq` always equals `coll_flag`.
- R9: Under the vicinity protocol (`proto_type_a` = 0), collisions never change the recorded position.
- R10: A cycle with `stat_rd` high clears `coll_flag` and `coll_irq`, unless a collision is accepted in that same cycle, in which case the flag stays set. Reading leaves the position unchanged.
- R11: `rx_start` clears the recorded position to zero and re-arms capture for the new frame. The mask bits are not affected.
- R12: A cycle with `mask_wr` high loads `mask_wdata` into `pos_mask_reg[5:0]` and leaves bits 7:6 unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| proto_type_a | input | 1 | 1 = proximity Type A (position recorded), 0 = vicinity (flag only) |
| frame_on | input | 1 | High while a receive frame is in progress |
| rx_start | input | 1 | One-cycle strobe: start bit detected |
| rx_bit_vld | input | 1 | One-cycle strobe: a decoded bit is present |
| rx_bit_coll | input | 1 | The present bit is a collision (qualified by rx_bit_vld) |
| stat_rd | input | 1 | Host read strobe of the interrupt status register |
| mask_wr | input | 1 | Host write strobe of the shared position/mask register |
| mask_wdata | input | 6 | Interrupt-mask bits to write |
| pos_lo | output | 8 | Recorded position, bits 7:0 |
| pos_mask_reg | output | 8 | Bits 7:6 = position bits 9:8; bits 5:0 = interrupt mask |
| coll_flag | output | 1 | Collision status flag |
| coll_irq | output | 1 | Interrupt request |

## Verification
Assertions check on every cycle that a start bit zeroes the count, that the count holds at its ceiling, and that a locked or vicinity-mode position does not move. They also check that an accepted collision always sets the flag, that a status read with no collision clears it, and that a mask write cannot disturb the position bits. Only the bench scenarios can show the actual number recorded for a collision at a chosen place in a frame: the value 16 for the first UID bit, the 1023 ceiling, and the split across the two bytes. The bench scenarios also cover the priority of the start strobe over a simultaneous bit and the outcome of a read that coincides with a collision.

// File: rtl/acp_pkg.sv
package acp_pkg;
  typedef enum logic {
    PROTO_VICINITY = 1'b0,
    PROTO_TYPE_A   = 1'b1
  } acp_proto_e;
endpackage

// File: rtl/acp_bit_counter.sv
module acp_bit_counter #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             take_i,
  output logic [CNT_W-1:0] count_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_o <= '0;
    end else if (start_i) begin
      count_o <= '0;
    end else if (take_i && count_o != CNT_MAX) begin
      count_o <= count_o + 1'b1;
    end
  end

  // R2
  start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> count_o == '0);

  // R7
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count_o == CNT_MAX && !start_i) |=> count_o == CNT_MAX);

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!take_i && !start_i) |=> $stable(count_o));
endmodule

// File: rtl/acp_pos_capture.sv
module acp_pos_capture
  import acp_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  acp_proto_e       proto_i,
  input  logic             start_i,
  input  logic             hit_i,
  input  logic [CNT_W-1:0] count_i,
  output logic [CNT_W-1:0] pos_o
);
  logic locked_q;
  logic grab;

  assign grab = hit_i && !locked_q && (proto_i == PROTO_TYPE_A);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_o    <= '0;
      locked_q <= 1'b0;
    end else if (start_i) begin
      pos_o    <= '0;
      locked_q <= 1'b0;
    end else if (grab) begin
      pos_o    <= count_i;
      locked_q <= 1'b1;
    end
  end

  // R6
  first_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (locked_q && !start_i) |=> $stable(pos_o));

  // R9
  vicinity_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (proto_i == PROTO_VICINITY && !start_i) |=> $stable(pos_o));

  // R11
  start_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (pos_o == '0 && !locked_q));
endmodule

// File: rtl/acp_irq_status.sv
module acp_irq_status (
  input  logic clk,
  input  logic rst_n,
  input  logic hit_i,
  input  logic rd_i,
  output logic flag_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_o <= 1'b0;
    end else if (hit_i) begin
      flag_o <= 1'b1;
    end else if (rd_i) begin
      flag_o <= 1'b0;
    end
  end

  // R8
  hit_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_i |=> flag_o);

  // R10
  read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && !hit_i) |=> !flag_o);
endmodule

// File: rtl/acoll_pos_capture.sv
module acoll_pos_capture
  import acp_pkg::*;
#(
  parameter int POS_W = 10,
  parameter int LO_W  = 8,
  parameter int REG_W = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      proto_type_a,
  input  logic                      frame_on,
  input  logic                      rx_start,
  input  logic                      rx_bit_vld,
  input  logic                      rx_bit_coll,
  input  logic                      stat_rd,
  input  logic                      mask_wr,
  input  logic [REG_W-(POS_W-LO_W)-1:0] mask_wdata,
  output logic [LO_W-1:0]           pos_lo,
  output logic [REG_W-1:0]          pos_mask_reg,
  output logic                      coll_flag,
  output logic                      coll_irq
);
  localparam int HI_W   = POS_W - LO_W;
  localparam int MASK_W = REG_W - HI_W;

  logic [POS_W-1:0]  bit_cnt;
  logic [POS_W-1:0]  pos;
  logic [MASK_W-1:0] mask_q;
  logic              take;
  logic              hit;
  acp_proto_e        proto;

  assign proto = acp_proto_e'(proto_type_a);
  assign take  = rx_bit_vld && frame_on;
  assign hit   = take && rx_bit_coll && !rx_start;

  acp_bit_counter #(.CNT_W(POS_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (rx_start),
    .take_i  (take),
    .count_o (bit_cnt)
  );

  acp_pos_capture #(.CNT_W(POS_W)) u_cap (
    .clk     (clk),
    .rst_n   (rst_n),
    .proto_i (proto),
    .start_i (rx_start),
    .hit_i   (hit),
    .count_i (bit_cnt),
    .pos_o   (pos)
  );

  acp_irq_status u_stat (
    .clk    (clk),
    .rst_n  (rst_n),
    .hit_i  (hit),
    .rd_i   (stat_rd),
    .flag_o (coll_flag)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (mask_wr) begin
      mask_q <= mask_wdata;
    end
  end

  assign pos_lo       = pos[LO_W-1:0];
  assign pos_mask_reg = {pos[POS_W-1:LO_W], mask_q};
  assign coll_irq     = coll_flag;

  // R12
  mask_keeps_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_wr && !rx_start && !hit) |=> $stable(pos_mask_reg[REG_W-1:MASK_W]));

  // R10
  read_keeps_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !rx_start && !hit) |=> $stable(pos_lo));
endmodule

// File: tb/acoll_pos_capture_bench.sv
module acoll_pos_capture_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic proto_type_a = 1'b1, frame_on = 1'b0, rx_start = 1'b0;
  logic rx_bit_vld = 1'b0, rx_bit_coll = 1'b0, stat_rd = 1'b0, mask_wr = 1'b0;
  logic [5:0] mask_wdata = '0;
  logic [7:0] pos_lo, pos_mask_reg;
  logic coll_flag, coll_irq;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  acoll_pos_capture u_acoll_pos_capture (
    .clk(clk), .rst_n(rst_n), .proto_type_a(proto_type_a), .frame_on(frame_on),
    .rx_start(rx_start), .rx_bit_vld(rx_bit_vld), .rx_bit_coll(rx_bit_coll),
    .stat_rd(stat_rd), .mask_wr(mask_wr), .mask_wdata(mask_wdata),
    .pos_lo(pos_lo), .pos_mask_reg(pos_mask_reg), .coll_flag(coll_flag),
    .coll_irq(coll_irq)
  );

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [9:0] got_pos();
    return {pos_mask_reg[7:6], pos_lo};
  endfunction

  task automatic start_frame();
    @(negedge clk); frame_on = 1'b1; rx_start = 1'b1;
    @(negedge clk); rx_start = 1'b0;
  endtask

  task automatic send_bits(int n, bit coll);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); rx_bit_vld = 1'b1; rx_bit_coll = coll;
    end
    @(negedge clk); rx_bit_vld = 1'b0; rx_bit_coll = 1'b0;
  endtask

  task automatic read_status();
    @(negedge clk); stat_rd = 1'b1;
    @(negedge clk); stat_rd = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 pos_lo", pos_lo, 0);
    check("R1 pos_mask_reg", pos_mask_reg, 0);
    check("R1 flag", coll_flag, 0);
    check("R1 irq", coll_irq, 0);
  endtask

  task automatic t_first_uid_bit();
    proto_type_a = 1'b1;
    start_frame();
    send_bits(16, 1'b0);
    check("R8 no flag on clean bits", coll_flag, 0);
    send_bits(1, 1'b1);
    check("R4 position 16", got_pos(), 10'd16);
    check("R8 flag", coll_flag, 1);
    check("R8 irq", coll_irq, 1);
    send_bits(3, 1'b0);
    send_bits(1, 1'b1);
    check("R6 later collision ignored", got_pos(), 10'd16);
    read_status();
    check("R10 read clears flag", coll_flag, 0);
    check("R10 read clears irq", coll_irq, 0);
    check("R10 read keeps position", got_pos(), 10'd16);
  endtask

  task automatic t_split_hi();
    start_frame();
    check("R11 start clears position", got_pos(), 0);
    send_bits(300, 1'b0);
    send_bits(1, 1'b1);
    check("R5 low byte", pos_lo, 8'd44);
    check("R5 high bits", pos_mask_reg[7:6], 2'b01);
    @(negedge clk); mask_wr = 1'b1; mask_wdata = 6'h2B;
    @(negedge clk); mask_wr = 1'b0;
    check("R12 mask bits", pos_mask_reg[5:0], 6'h2B);
    check("R12 high bits kept", pos_mask_reg[7:6], 2'b01);
    start_frame();
    check("R11 mask kept over start", pos_mask_reg, 8'h2B);
    read_status();
  endtask

  task automatic t_position_zero_and_priority();
    start_frame();
    @(negedge clk); rx_start = 1'b1; rx_bit_vld = 1'b1; rx_bit_coll = 1'b1;
    @(negedge clk); rx_start = 1'b0; rx_bit_vld = 1'b0; rx_bit_coll = 1'b0;
    check("R2 bit with start ignored flag", coll_flag, 0);
    send_bits(1, 1'b0);
    send_bits(1, 1'b1);
    check("R2 count from zero", got_pos(), 10'd1);
    read_status();
  endtask

  task automatic t_frame_gate();
    start_frame();
    frame_on = 1'b0;
    send_bits(5, 1'b1);
    check("R3 inactive bits no flag", coll_flag, 0);
    frame_on = 1'b1;
    send_bits(2, 1'b0);
    send_bits(1, 1'b1);
    check("R3 inactive bits not counted", got_pos(), 10'd2);
    read_status();
  endtask

  task automatic t_saturate();
    start_frame();
    send_bits(1100, 1'b0);
    send_bits(1, 1'b1);
    check("R7 saturated position", got_pos(), 10'd1023);
    read_status();
  endtask

  task automatic t_vicinity();
    proto_type_a = 1'b0;
    start_frame();
    send_bits(7, 1'b0);
    send_bits(1, 1'b1);
    check("R9 position untouched", got_pos(), 0);
    check("R8 vicinity flag", coll_flag, 1);
    @(negedge clk); stat_rd = 1'b1; rx_bit_vld = 1'b1; rx_bit_coll = 1'b1;
    @(negedge clk); stat_rd = 1'b0; rx_bit_vld = 1'b0; rx_bit_coll = 1'b0;
    check("R10 collision beats read", coll_flag, 1);
    read_status();
    check("R10 flag cleared", coll_flag, 0);
    proto_type_a = 1'b1;
  endtask

  initial begin
    #1;
    t_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_first_uid_bit();
    t_split_hi();
    t_position_zero_and_priority();
    t_frame_gate();
    t_saturate();
    t_vicinity();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule